// File: doc/BRIEF.md
# Three-Slot CAN Transmit Buffer Manager

This block keeps three outgoing CAN message slots. Each slot holds a frame descriptor (data length, remote-frame flag, identifier width), an identifier and eight payload bytes. Software fills a free slot through a word-wide write port, then issues a command that queues one or more slots for ordinary transmission or for self-reception, or that aborts them. The block offers queued slots one at a time to a frame transmitter over a valid/ready handshake. The transmitter reports completion with a "sent" pulse, or confirms an abort with an acknowledge pulse.

Status outputs give one free bit per slot, the lowest free slot index, an all-free flag and a refusal pulse for commands that cannot be honoured. Each slot has an interrupt that latches when the slot becomes free while its enable is set. A capture-read strobe clears the latched interrupts.

Top module: `can_txslots`

## Requirements
- R1: After reset all slots read free (`slotFree` = all ones), `allDone` = 1, `anyFree` = 1, `nextFree` = 0, `irqPend` = 0 and `txValid` = 0.
- R2: A write to a free slot stores a field chosen by `wrField`: 0 = descriptor (length in bits 19:16, remote flag in bit 30, extended-identifier flag in bit 31), 1 = identifier, 2 = payload bytes 0..3 (`txData[31:0]`), 3 = payload bytes 4..7 (`txData[63:32]`). When the slot is offered, `txId` carries all 29 identifier bits if the extended flag is set, and only the low 11 bits otherwise.
- R3: An accepted send command (`cmdSend` or `cmdSelfRx`) clears `slotFree` for every selected slot at the next edge. A send command is refused as a whole when it selects no slot or any selected slot that is not free, which includes the case where all three slots are busy. A refused command raises `cmdRefused` for one cycle after the edge and leaves `slotFree` unchanged.
- R4: Of the queued slots, the lowest-numbered one is offered (`txValid`, `txSlot`) first. Only one slot is in flight at a time, and `txValid` stays low until that slot is finished.
- R5: A `txSent` pulse frees the in-flight slot at that edge. If the slot's `irqEn` bit is set, the matching `irqPend` bit is set at the same edge. If the enable is clear, the bit is not set.
- R6: An interrupt bit is set only when its slot goes from busy to free. A slot that stays free does not set it again after it has been cleared.
- R7: A `capRead` pulse clears all `irqPend` bits at that edge. A bit that is set at the same edge stays set.
- R8: Writes to a slot that is queued or in flight are ignored.
- R9: An abort command frees the selected queued slots at the next edge and raises their interrupts if enabled. For a selected slot that is in flight, it raises `txAbortReq` instead. That slot is freed, with its interrupt, when `txAbortAck` arrives.
- R10: A slot queued with `cmdSelfRx` is offered with `txSelfRx` = 1. A slot queued with `cmdSend` alone is offered with `txSelfRx` = 0.
- R11: `allDone` is 1 exactly when every slot is free. `nextFree` gives the lowest free slot index and is valid while `anyFree` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Slot field write strobe |
| wrSlot | input | 2 | Slot written |
| wrField | input | 2 | Field written (0 descriptor, 1 identifier, 2 low payload, 3 high payload) |
| wrData | input | 32 | Write data |
| cmdValid | input | 1 | Command strobe |
| cmdSel | input | 3 | Slot select mask for the command |
| cmdSend | input | 1 | Queue the selected slots for transmission |
| cmdSelfRx | input | 1 | Queue the selected slots for self-reception transmission |
| cmdAbort | input | 1 | Abort the selected slots (takes precedence over the send bits) |
| irqEn | input | 3 | Per-slot interrupt enable |
| capRead | input | 1 | Interrupt capture read, clears pending bits |
| slotFree | output | 3 | Per-slot free status |
| allDone | output | 1 | All slots free |
| anyFree | output | 1 | At least one slot free |
| nextFree | output | 2 | Lowest free slot index |
| cmdRefused | output | 1 | Previous send command was refused |
| irqPend | output | 3 | Latched per-slot interrupts |
| txValid | output | 1 | A queued slot is offered to the transmitter |
| txReady | input | 1 | Transmitter takes the offered slot |
| txSlot | output | 2 | Offered or in-flight slot index |
| txDlc | output | 4 | Data length of the offered slot |
| txRtr | output | 1 | Remote-frame flag of the offered slot |
| txExt | output | 1 | Extended-identifier flag of the offered slot |
| txId | output | 29 | Identifier of the offered slot |
| txData | output | 64 | Payload, byte 0 in bits 7:0 |
| txSelfRx | output | 1 | Offered slot uses self-reception |
| txSent | input | 1 | Transmitter finished the in-flight slot |
| txAbortReq | output | 1 | Abort requested for the in-flight slot |
| txAbortAck | input | 1 | Transmitter confirms the abort |

## Verification
Every register update lands on the edge that samples the stimulus. Slot status, interrupt bits, `cmdRefused` and `txAbortReq` therefore change one edge after a command, write or pulse. `txValid`, `txSlot` and the frame fields follow the slot state without further delay, so they are visible in the same cycle the slot state changes. The bench drives each stimulus for one cycle from a falling edge and samples at the following falling edge, which is after exactly one rising edge. It checks the frame fields while `txValid` is high and before it raises `txReady`.

// File: rtl/can_txslots_pkg.sv
package can_txslots_pkg;

  localparam int WORD_W       = 32;
  localparam int SEL_W        = 8;
  localparam int INFO_DLC_LSB = 16;
  localparam int INFO_RTR_BIT = 30;
  localparam int INFO_EXT_BIT = 31;

  typedef enum logic [1:0] {
    FLD_INFO = 2'd0,
    FLD_ID   = 2'd1,
    FLD_DLO  = 2'd2,
    FLD_DHI  = 2'd3
  } fieldSel_e;

  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_QUEUED = 2'd1,
    SLOT_ACTIVE = 2'd2
  } slotState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             wrStb;
    fieldSel_e        wrField;
    logic [SEL_W-1:0] wrSlot;
    logic [SEL_W-1:0] outSlot;
  } dpStrobes_t;

endpackage

// File: rtl/can_txslots_dp.sv
module can_txslots_dp
  import can_txslots_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int DLC_W     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          stb,
  input  logic [WORD_W-1:0]   wrData,
  output logic [DLC_W-1:0]    txDlc,
  output logic                txRtr,
  output logic                txExt,
  output logic [ID_W-1:0]     txId,
  output logic [2*WORD_W-1:0] txData
);

  logic [DLC_W-1:0]  dlcQ  [NUM_SLOTS];
  logic [ID_W-1:0]   idQ   [NUM_SLOTS];
  logic [WORD_W-1:0] loQ   [NUM_SLOTS];
  logic [WORD_W-1:0] hiQ   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] rtrQ;
  logic [NUM_SLOTS-1:0] extQ;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic hit;
    assign hit = stb.wrStb && (stb.wrSlot == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dlcQ[g] <= '0;
        idQ[g]  <= '0;
        loQ[g]  <= '0;
        hiQ[g]  <= '0;
        rtrQ[g] <= 1'b0;
        extQ[g] <= 1'b0;
      end else if (hit) begin
        unique case (stb.wrField)
          FLD_INFO: begin
            dlcQ[g] <= wrData[INFO_DLC_LSB +: DLC_W];
            rtrQ[g] <= wrData[INFO_RTR_BIT];
            extQ[g] <= wrData[INFO_EXT_BIT];
          end
          FLD_ID:  idQ[g] <= wrData[ID_W-1:0];
          FLD_DLO: loQ[g] <= wrData;
          FLD_DHI: hiQ[g] <= wrData;
          default: ;
        endcase
      end
    end
  end

  logic [ID_W-1:0] idSel;

  always_comb begin
    txDlc  = dlcQ[0];
    txRtr  = rtrQ[0];
    txExt  = extQ[0];
    idSel  = idQ[0];
    txData = {hiQ[0], loQ[0]};
    for (int i = 1; i < NUM_SLOTS; i++) begin
      if (stb.outSlot == SEL_W'(i)) begin
        txDlc  = dlcQ[i];
        txRtr  = rtrQ[i];
        txExt  = extQ[i];
        idSel  = idQ[i];
        txData = {hiQ[i], loQ[i]};
      end
    end
    txId = txExt ? idSel : ID_W'(idSel[STD_ID_W-1:0]);
  end

endmodule

// File: rtl/can_txslots_ctrl.sv
module can_txslots_ctrl
  import can_txslots_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic [1:0]           wrField,
  input  logic                 cmdValid,
  input  logic [NUM_SLOTS-1:0] cmdSel,
  input  logic                 cmdSend,
  input  logic                 cmdSelfRx,
  input  logic                 cmdAbort,
  input  logic [NUM_SLOTS-1:0] irqEn,
  input  logic                 capRead,
  input  logic                 txReady,
  input  logic                 txSent,
  input  logic                 txAbortAck,
  output dpStrobes_t           stb,
  output logic [NUM_SLOTS-1:0] slotFree,
  output logic                 allDone,
  output logic                 anyFree,
  output logic [SLOT_W-1:0]    nextFree,
  output logic                 cmdRefused,
  output logic [NUM_SLOTS-1:0] irqPend,
  output logic                 txValid,
  output logic [SLOT_W-1:0]    txSlot,
  output logic                 txSelfRx,
  output logic                 txAbortReq
);

  slotState_e state  [NUM_SLOTS];
  slotState_e stNext [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] srrQ, srrNext;
  logic [NUM_SLOTS-1:0] isFree, isQueued, isActive, nowFree, becameFree;
  logic abortHold, holdNext;

  logic [SLOT_W-1:0] qIdx, aIdx;
  logic qAny, aAny;
  logic sendReq, refuse, sendOk, abortReq, accept, activeLeaves, wrHit;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      isFree[i]   = (state[i] == SLOT_FREE);
      isQueued[i] = (state[i] == SLOT_QUEUED);
      isActive[i] = (state[i] == SLOT_ACTIVE);
    end
  end

  // lowest-index pickers
  always_comb begin
    qIdx = '0; qAny = 1'b0;
    aIdx = '0; aAny = 1'b0;
    nextFree = '0; anyFree = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (isQueued[i]) begin qIdx = SLOT_W'(i); qAny = 1'b1; end
      if (isActive[i]) begin aIdx = SLOT_W'(i); aAny = 1'b1; end
      if (isFree[i])   begin nextFree = SLOT_W'(i); anyFree = 1'b1; end
    end
  end

  assign sendReq  = cmdValid && (cmdSend || cmdSelfRx) && !cmdAbort;
  assign refuse   = sendReq && ((cmdSel == '0) || ((cmdSel & ~isFree) != '0));
  assign sendOk   = sendReq && !refuse;
  assign abortReq = cmdValid && cmdAbort;

  assign txValid  = qAny && !aAny;
  assign txSlot   = aAny ? aIdx : qIdx;
  assign accept   = txValid && txReady;
  assign activeLeaves = aAny && (txSent || (txAbortAck && abortHold));

  always_comb begin
    txSelfRx = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (txSlot == SLOT_W'(i)) txSelfRx = srrQ[i];
  end

  always_comb begin
    srrNext = srrQ;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      stNext[i] = state[i];
      unique case (state[i])
        SLOT_FREE:
          if (sendOk && cmdSel[i]) begin
            stNext[i]  = SLOT_QUEUED;
            srrNext[i] = cmdSelfRx;
          end
        SLOT_QUEUED:
          if (abortReq && cmdSel[i])
            stNext[i] = SLOT_FREE;
          else if (accept && (qIdx == SLOT_W'(i)))
            stNext[i] = SLOT_ACTIVE;
        SLOT_ACTIVE:
          if (activeLeaves) stNext[i] = SLOT_FREE;
        default: stNext[i] = SLOT_FREE;
      endcase
      nowFree[i]    = (stNext[i] == SLOT_FREE);
      becameFree[i] = !isFree[i] && nowFree[i];
    end
  end

  always_comb begin
    holdNext = abortHold;
    if (activeLeaves)
      holdNext = 1'b0;
    else if (abortReq && ((cmdSel & isActive) != '0))
      holdNext = 1'b1;
  end

  always_comb begin
    wrHit = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if ((wrSlot == SLOT_W'(i)) && isFree[i]) wrHit = 1'b1;
  end

  assign stb.wrStb   = wrEn && wrHit;
  assign stb.wrField = fieldSel_e'(wrField);
  assign stb.wrSlot  = SEL_W'(wrSlot);
  assign stb.outSlot = SEL_W'(txSlot);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) state[i] <= SLOT_FREE;
      srrQ       <= '0;
      abortHold  <= 1'b0;
      irqPend    <= '0;
      cmdRefused <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) state[i] <= stNext[i];
      srrQ       <= srrNext;
      abortHold  <= holdNext;
      irqPend    <= (capRead ? '0 : irqPend) | (becameFree & irqEn);
      cmdRefused <= refuse;
    end
  end

  assign slotFree   = isFree;
  assign allDone    = &isFree;
  assign txAbortReq = abortHold;

endmodule

// File: rtl/can_txslots.sv
module can_txslots
  import can_txslots_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int DLC_W     = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic [1:0]           wrField,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 cmdValid,
  input  logic [NUM_SLOTS-1:0] cmdSel,
  input  logic                 cmdSend,
  input  logic                 cmdSelfRx,
  input  logic                 cmdAbort,
  input  logic [NUM_SLOTS-1:0] irqEn,
  input  logic                 capRead,
  output logic [NUM_SLOTS-1:0] slotFree,
  output logic                 allDone,
  output logic                 anyFree,
  output logic [SLOT_W-1:0]    nextFree,
  output logic                 cmdRefused,
  output logic [NUM_SLOTS-1:0] irqPend,
  output logic                 txValid,
  input  logic                 txReady,
  output logic [SLOT_W-1:0]    txSlot,
  output logic [DLC_W-1:0]     txDlc,
  output logic                 txRtr,
  output logic                 txExt,
  output logic [ID_W-1:0]      txId,
  output logic [2*WORD_W-1:0]  txData,
  output logic                 txSelfRx,
  input  logic                 txSent,
  output logic                 txAbortReq,
  input  logic                 txAbortAck
);

  dpStrobes_t stb;

  can_txslots_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSlot(wrSlot), .wrField(wrField),
    .cmdValid(cmdValid), .cmdSel(cmdSel), .cmdSend(cmdSend),
    .cmdSelfRx(cmdSelfRx), .cmdAbort(cmdAbort),
    .irqEn(irqEn), .capRead(capRead),
    .txReady(txReady), .txSent(txSent), .txAbortAck(txAbortAck),
    .stb(stb),
    .slotFree(slotFree), .allDone(allDone), .anyFree(anyFree),
    .nextFree(nextFree), .cmdRefused(cmdRefused), .irqPend(irqPend),
    .txValid(txValid), .txSlot(txSlot), .txSelfRx(txSelfRx),
    .txAbortReq(txAbortReq)
  );

  can_txslots_dp #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .STD_ID_W(STD_ID_W), .DLC_W(DLC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .txDlc(txDlc), .txRtr(txRtr), .txExt(txExt), .txId(txId), .txData(txData)
  );

endmodule

// File: rtl/can_txslots_chk.sv
module can_txslots_chk #(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] slotFree,
  input logic [NUM_SLOTS-1:0] irqPend,
  input logic [NUM_SLOTS-1:0] irqEn,
  input logic                 capRead,
  input logic                 txValid,
  input logic [SLOT_W-1:0]    txSlot,
  input logic                 txAbortReq,
  input logic                 allDone
);

  // R4: the offered slot is never a free slot
  a_r4_offer_busy: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (((slotFree >> txSlot) & 1) == 0));

  // R4: nothing is offered while a slot is still in flight under abort
  a_r4_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    txAbortReq |-> !txValid);

  // R11: all free means nothing offered and nothing to abort
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    allDone |-> (!txValid && !txAbortReq));

  // R6: a newly set interrupt bit belongs to a freed slot with its enable set
  a_r6_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend & ~$past(irqPend) & ~(slotFree & $past(irqEn))) == '0);

  // R7: after a capture read with no status change, no bit is pending
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(capRead) && ($past(slotFree) == slotFree)) |-> (irqPend == '0));

endmodule

bind can_txslots can_txslots_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .slotFree(slotFree), .irqPend(irqPend),
  .irqEn(irqEn), .capRead(capRead), .txValid(txValid), .txSlot(txSlot),
  .txAbortReq(txAbortReq), .allDone(allDone)
);

// File: tb/sim_can_txslots.sv
`timescale 1ns/1ps
module sim_can_txslots;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSlot = '0;
  logic [1:0]  wrField = '0;
  logic [31:0] wrData = '0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdSel = '0;
  logic        cmdSend = 1'b0, cmdSelfRx = 1'b0, cmdAbort = 1'b0;
  logic [2:0]  irqEn = 3'b111;
  logic        capRead = 1'b0;
  logic [2:0]  slotFree;
  logic        allDone, anyFree, cmdRefused;
  logic [1:0]  nextFree;
  logic [2:0]  irqPend;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [1:0]  txSlot;
  logic [3:0]  txDlc;
  logic        txRtr, txExt, txSelfRx, txAbortReq;
  logic [28:0] txId;
  logic [63:0] txData;
  logic        txSent = 1'b0, txAbortAck = 1'b0;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  can_txslots u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot), .wrField(wrField),
    .wrData(wrData), .cmdValid(cmdValid), .cmdSel(cmdSel), .cmdSend(cmdSend),
    .cmdSelfRx(cmdSelfRx), .cmdAbort(cmdAbort), .irqEn(irqEn), .capRead(capRead),
    .slotFree(slotFree), .allDone(allDone), .anyFree(anyFree), .nextFree(nextFree),
    .cmdRefused(cmdRefused), .irqPend(irqPend), .txValid(txValid), .txReady(txReady),
    .txSlot(txSlot), .txDlc(txDlc), .txRtr(txRtr), .txExt(txExt), .txId(txId),
    .txData(txData), .txSelfRx(txSelfRx), .txSent(txSent), .txAbortReq(txAbortReq),
    .txAbortAck(txAbortAck)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected frame content per slot, derived from the field encoding
  function automatic logic [3:0]  eDlc(int s); return 4'(s + 5); endfunction
  function automatic logic        eExt(int s); return s == 1; endfunction
  function automatic logic        eRtr(int s); return s == 2; endfunction
  function automatic logic [28:0] eRawId(int s); return 29'h0ABC_DE5 + 29'(s * 29'h0111_1111); endfunction
  function automatic logic [28:0] eId(int s);
    return eExt(s) ? eRawId(s) : {18'b0, eRawId(s)[10:0]};
  endfunction
  function automatic logic [31:0] eLo(int s); return 32'h1122_3344 ^ (32'(s) * 32'h0101_0101); endfunction
  function automatic logic [31:0] eHi(int s); return 32'h5566_7788 + 32'(s) * 32'h1000_0001; endfunction

  task automatic wr(input int s, input int f, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrSlot = 2'(s); wrField = 2'(f); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] sel, input logic snd, input logic srr, input logic abt);
    @(negedge clk); cmdValid = 1'b1; cmdSel = sel; cmdSend = snd; cmdSelfRx = srr; cmdAbort = abt;
    @(negedge clk); cmdValid = 1'b0; cmdSend = 1'b0; cmdSelfRx = 1'b0; cmdAbort = 1'b0;
  endtask

  task automatic acceptOne();
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
  endtask

  task automatic pulseSent();
    @(negedge clk); txSent = 1'b1;
    @(negedge clk); txSent = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); txAbortAck = 1'b1;
    @(negedge clk); txAbortAck = 1'b0;
  endtask

  task automatic capture();
    @(negedge clk); capRead = 1'b1;
    @(negedge clk); capRead = 1'b0;
  endtask

  task automatic chkFrame(input int s, input string tag);
    chk({tag, " valid"}, 64'(txValid), 64'd1);
    chk({tag, " slot"},  64'(txSlot), 64'(s));
    chk({tag, " dlc"},   64'(txDlc), 64'(eDlc(s)));
    chk({tag, " rtr"},   64'(txRtr), 64'(eRtr(s)));
    chk({tag, " ext"},   64'(txExt), 64'(eExt(s)));
    chk({tag, " id"},    64'(txId), 64'(eId(s)));
    chk({tag, " data"},  txData, {eHi(s), eLo(s)});
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 slotFree", 64'(slotFree), 64'h7);
    chk("R1 allDone",  64'(allDone), 64'd1);
    chk("R1 anyFree",  64'(anyFree), 64'd1);
    chk("R1 nextFree", 64'(nextFree), 64'd0);
    chk("R1 irqPend",  64'(irqPend), 64'd0);
    chk("R1 txValid",  64'(txValid), 64'd0);

    // R2 fill all slots through the write port
    for (int s = 0; s < 3; s++) begin
      wr(s, 0, {eExt(s), eRtr(s), 10'b0, eDlc(s), 16'b0});
      wr(s, 1, {3'b0, eRawId(s)});
      wr(s, 2, eLo(s));
      wr(s, 3, eHi(s));
    end

    // R3 queue all three at once
    cmd(3'b111, 1'b1, 1'b0, 1'b0);
    chk("R3 slotFree after send", 64'(slotFree), 64'h0);
    chk("R11 allDone busy", 64'(allDone), 64'd0);
    chk("R11 anyFree busy", 64'(anyFree), 64'd0);
    chk("R4 lowest first", 64'(txSlot), 64'd0);

    // R3 no slot free: refused
    cmd(3'b001, 1'b1, 1'b0, 1'b0);
    chk("R3 refused pulse", 64'(cmdRefused), 64'd1);
    chk("R3 refused status", 64'(slotFree), 64'h0);

    // R8 write to busy slot ignored
    wr(0, 2, 32'hDEAD_BEEF);
    wr(0, 1, 32'h1FFF_FFFF);
    chk("R3 refused pulse one cycle", 64'(cmdRefused), 64'd0);
    chkFrame(0, "R2 R8 slot0");
    chk("R10 plain send", 64'(txSelfRx), 64'd0);

    acceptOne();
    chk("R4 one in flight", 64'(txValid), 64'd0);
    pulseSent();
    chk("R5 slot0 freed", 64'(slotFree), 64'h1);
    chk("R5 irq slot0", 64'(irqPend), 64'h1);
    chk("R4 next offered", 64'(txSlot), 64'd1);
    chk("R11 nextFree", 64'(nextFree), 64'd0);

    capture();
    chk("R7 cleared", 64'(irqPend), 64'h0);
    @(negedge clk);
    chk("R6 no re-fire", 64'(irqPend), 64'h0);

    // R5 disabled interrupt
    irqEn = 3'b101;
    chkFrame(1, "R2 slot1 ext");
    acceptOne();
    pulseSent();
    chk("R5 slot1 freed", 64'(slotFree), 64'h3);
    chk("R5 irq disabled", 64'(irqPend), 64'h0);

    // R9 abort a queued slot
    irqEn = 3'b111;
    chkFrame(2, "R2 slot2 rtr");
    cmd(3'b100, 1'b0, 1'b0, 1'b1);
    chk("R9 queued abort freed", 64'(slotFree), 64'h7);
    chk("R9 queued abort irq", 64'(irqPend), 64'h4);
    chk("R11 allDone", 64'(allDone), 64'd1);
    chk("R9 no offer", 64'(txValid), 64'd0);
    capture();

    // R10 self-reception, R9 in-flight abort
    wr(0, 2, 32'hCAFE_F00D);
    cmd(3'b001, 1'b0, 1'b1, 1'b0);
    chk("R10 selfrx flag", 64'(txSelfRx), 64'd1);
    chk("R2 rewrite data", 64'(txData[31:0]), 64'hCAFE_F00D);
    acceptOne();
    cmd(3'b001, 1'b0, 1'b0, 1'b1);
    chk("R9 abort req", 64'(txAbortReq), 64'd1);
    chk("R9 still busy", 64'(slotFree), 64'h6);
    pulseAck();
    chk("R9 ack freed", 64'(slotFree), 64'h7);
    chk("R9 ack req drop", 64'(txAbortReq), 64'd0);
    chk("R9 ack irq", 64'(irqPend), 64'h1);

    // R7 set and read on the same edge
    cmd(3'b010, 1'b1, 1'b0, 1'b0);
    chk("R10 plain slot1", 64'(txSelfRx), 64'd0);
    acceptOne();
    @(negedge clk); txSent = 1'b1; capRead = 1'b1;
    @(negedge clk); txSent = 1'b0; capRead = 1'b0;
    chk("R7 set wins", 64'(irqPend), 64'h2);
    capture();

    // R11 lowest free sweep, R3 refusals
    for (int k = 0; k < 3; k++) begin
      cmd(3'(1 << k), 1'b1, 1'b0, 1'b0);
      chk("R11 anyFree sweep", 64'(anyFree), 64'(k < 2));
      if (k < 2) chk("R11 nextFree sweep", 64'(nextFree), 64'(k + 1));
    end
    cmd(3'b001, 1'b1, 1'b0, 1'b0);
    chk("R3 all busy refused", 64'(cmdRefused), 64'd1);
    cmd(3'b000, 1'b1, 1'b0, 1'b0);
    chk("R3 empty select refused", 64'(cmdRefused), 64'd1);
    cmd(3'b111, 1'b0, 1'b0, 1'b1);
    chk("R9 abort all", 64'(slotFree), 64'h7);
    chk("R9 abort all irq", 64'(irqPend), 64'h7);
    chk("R11 allDone end", 64'(allDone), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule